// File: doc/BRIEF.md
# Two-Stage Fetch Front End with Redirect Squash

This block is the front end of a small 16-bit processor whose memories count 16-bit words. It has two stages. In fetch, it drives the program counter onto the instruction memory address. The memory returns the word in the same cycle, and the block latches that word and its address into a pipeline register. In the next cycle the execute stage decodes and runs the instruction. The execute stage then reports back how control flow resolved: no change, a conditional branch with its outcome, a page-relative absolute jump, or a jump through a register.

The block reads the jump and branch fields from the instruction it holds and forms the next fetch address. The page comes from the registered PC of the executing instruction. When control leaves the sequential path, the word fetched in that cycle is on the wrong path. The block writes the zero word, which is a nop, into the pipeline register in its place. On the same edge it loads the target into the program counter. A conditional branch that is not taken lets the fetched word through unchanged.

Top module: `pc_fetch_front`

## Requirements
- R1: A synchronous active-high reset sets the fetch address, the held instruction and the held PC all to 0x0000.
- R2: In the first cycle after reset is released, the execute side sees the nop 0x0000 while address 0x0000 is fetched. One cycle later it sees the word stored at address 0x0000.
- R3: When there is no redirect, the fetch address advances by one word per cycle and wraps from 0xFFFF to 0x0000.
- R4: At every clock edge the held PC takes the fetch address of that cycle. With no redirect, the held instruction takes the word that memory returned for that address.
- R5: When a branch is taken, the next fetch address is held PC + 1 + the sign-extended held instruction bits [7:0].
- R6: When a branch is not taken, nothing is squashed and the fetch continues sequentially.
- R7: On an absolute jump, the next fetch address is the held PC bits [15:12] joined with the held instruction bits [11:0]. No low-order zeros are appended.
- R8: On a register jump, the next fetch address is the full 16-bit register value supplied by execute.
- R9: On any redirect, the held instruction becomes 0x0000 on the same edge that loads the target into the fetch address.
- R10: The redirect kind is encoded as 2'b00 none, 2'b01 branch, 2'b10 absolute jump and 2'b11 register jump. The taken input has no effect unless the kind is 2'b01.
- R11: All address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 16 | Fetch address to instruction memory |
| imem_rdata | input | 16 | Word returned for imem_addr in the same cycle |
| ex_instr | output | 16 | Instruction held for the execute stage |
| ex_pc | output | 16 | Address the held instruction was fetched from |
| ex_redir_kind | input | 2 | Control-flow kind resolved in execute |
| ex_br_taken | input | 1 | Branch condition result |
| ex_reg_target | input | 16 | Register value for a register jump |

## Verification
A behavioural reference model is stepped in lockstep with the design, and all three outputs are compared every cycle. The model is driven first by directed patterns and then by a long pseudorandom mix of redirect kinds.

- Plain sequential runs separate correct capture of the fetched word from off-by-one PC pairing.
- Not-taken branches and stray taken flags under other kinds separate over-eager squashing from correct squashing.
- A register jump to the top of memory, followed by sequential fetches and a branch, exposes missing wrap-around and wrong offset sign extension.
- An absolute jump taken from a nonzero page shows whether the page bits come from the held PC or are lost.

// File: rtl/fe_pkg.sv
package fe_pkg;
  typedef enum logic [1:0] {
    RD_NONE   = 2'b00,
    RD_BRANCH = 2'b01,
    RD_JABS   = 2'b10,
    RD_JREG   = 2'b11
  } redir_kind_e;
endpackage

// File: rtl/redirect_resolve.sv
// Decides whether execute redirects fetch and forms the target address.
module redirect_resolve #(
  parameter int W         = 16,
  parameter int PAGE_BITS = 4,
  parameter int OFF_BITS  = 8
) (
  input  logic [1:0]             kind,
  input  logic                   br_taken,
  input  logic [W-1:0]           held_pc,
  input  logic [W-PAGE_BITS-1:0] field,
  input  logic [W-1:0]           reg_target,
  output logic                   redirect,
  output logic [W-1:0]           target
);
  import fe_pkg::*;
  localparam int JT_BITS = W - PAGE_BITS;

  redir_kind_e  k;
  logic [W-1:0] sext_off;
  logic [W-1:0] seq_after;

  assign k = redir_kind_e'(kind);

  generate
    if (OFF_BITS < W) begin : g_ext
      assign sext_off = {{(W-OFF_BITS){field[OFF_BITS-1]}}, field[OFF_BITS-1:0]};
    end else begin : g_full
      assign sext_off = field[W-1:0];
    end
  endgenerate

  assign seq_after = held_pc + {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    redirect = 1'b0;
    target   = seq_after;
    unique case (k)
      RD_BRANCH: begin
        redirect = br_taken;
        target   = seq_after + sext_off;
      end
      RD_JABS: begin
        redirect = 1'b1;
        target   = {held_pc[W-1 -: PAGE_BITS], field[JT_BITS-1:0]};
      end
      RD_JREG: begin
        redirect = 1'b1;
        target   = reg_target;
      end
      default: begin
        redirect = 1'b0;
        target   = seq_after;
      end
    endcase
  end
endmodule

// File: rtl/pc_reg_stage.sv
// Fetch program counter: steps by one word or loads a redirect target.
module pc_reg_stage #(
  parameter int W = 16,
  parameter logic [W-1:0] RESET_PC = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] target,
  output logic [W-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst)       pc <= RESET_PC;
    else if (load) pc <= target;
    else           pc <= pc + {{(W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/ir_stage.sv
// Fetch/execute pipeline register holding the instruction and its address.
module ir_stage #(
  parameter int W = 16,
  parameter logic [W-1:0] NOP = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         squash,
  input  logic [W-1:0] fetch_word,
  input  logic [W-1:0] fetch_pc,
  output logic [W-1:0] held_instr,
  output logic [W-1:0] held_pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held_instr <= NOP;
      held_pc    <= '0;
    end else begin
      held_instr <= squash ? NOP : fetch_word;
      held_pc    <= fetch_pc;
    end
  end
endmodule

// File: rtl/pc_fetch_front.sv
module pc_fetch_front #(
  parameter int W         = 16,
  parameter int PAGE_BITS = 4,
  parameter int OFF_BITS  = 8
) (
  input  logic         clk,
  input  logic         rst,
  output logic [15:0]  imem_addr,
  input  logic [15:0]  imem_rdata,
  output logic [15:0]  ex_instr,
  output logic [15:0]  ex_pc,
  input  logic [1:0]   ex_redir_kind,
  input  logic         ex_br_taken,
  input  logic [15:0]  ex_reg_target
);
  localparam int JT_BITS = W - PAGE_BITS;
  localparam logic [W-1:0] NOP_WORD = '0;

  logic         redirect;
  logic [W-1:0] next_target;
  logic [W-1:0] fetch_pc;
  logic [W-1:0] held_instr;
  logic [W-1:0] held_pc;

  redirect_resolve #(.W(W), .PAGE_BITS(PAGE_BITS), .OFF_BITS(OFF_BITS)) u_resolve (
    .kind       (ex_redir_kind),
    .br_taken   (ex_br_taken),
    .held_pc    (held_pc),
    .field      (held_instr[JT_BITS-1:0]),
    .reg_target (ex_reg_target),
    .redirect   (redirect),
    .target     (next_target)
  );

  pc_reg_stage #(.W(W), .RESET_PC('0)) u_pc (
    .clk    (clk),
    .rst    (rst),
    .load   (redirect),
    .target (next_target),
    .pc     (fetch_pc)
  );

  ir_stage #(.W(W), .NOP(NOP_WORD)) u_ir (
    .clk        (clk),
    .rst        (rst),
    .squash     (redirect),
    .fetch_word (imem_rdata),
    .fetch_pc   (fetch_pc),
    .held_instr (held_instr),
    .held_pc    (held_pc)
  );

  assign imem_addr = fetch_pc;
  assign ex_instr  = held_instr;
  assign ex_pc     = held_pc;
endmodule

// File: rtl/fetch_front_checker.sv
module fetch_front_checker (
  input logic        clk,
  input logic        rst,
  input logic [15:0] imem_addr,
  input logic [15:0] imem_rdata,
  input logic [15:0] ex_instr,
  input logic [15:0] ex_pc,
  input logic [1:0]  ex_redir_kind,
  input logic        ex_br_taken,
  input logic [15:0] ex_reg_target
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (imem_addr == 16'h0000 && ex_instr == 16'h0000 && ex_pc == 16'h0000)); // R1

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (ex_redir_kind == 2'b00) |=> imem_addr == 16'($past(imem_addr) + 16'd1)); // R3

  AST_PC_PAIRING: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ex_pc == $past(imem_addr)); // R4

  AST_NOT_TAKEN_PASSES: assert property (@(posedge clk) disable iff (rst)
    (ex_redir_kind == 2'b01 && !ex_br_taken) |=> ex_instr == $past(imem_rdata)); // R6

  AST_JUMP_SQUASH: assert property (@(posedge clk) disable iff (rst)
    (ex_redir_kind[1] || (ex_redir_kind == 2'b01 && ex_br_taken)) |=> ex_instr == 16'h0000); // R9

  AST_JREG_TARGET: assert property (@(posedge clk) disable iff (rst)
    (ex_redir_kind == 2'b11) |=> imem_addr == $past(ex_reg_target)); // R8

  AST_JABS_PAGE: assert property (@(posedge clk) disable iff (rst)
    (ex_redir_kind == 2'b10) |=> imem_addr[15:12] == $past(ex_pc[15:12])); // R7
endmodule

bind pc_fetch_front fetch_front_checker u_fetch_front_checker (
  .clk           (clk),
  .rst           (rst),
  .imem_addr     (imem_addr),
  .imem_rdata    (imem_rdata),
  .ex_instr      (ex_instr),
  .ex_pc         (ex_pc),
  .ex_redir_kind (ex_redir_kind),
  .ex_br_taken   (ex_br_taken),
  .ex_reg_target (ex_reg_target)
);

// File: tb/pc_fetch_front_bench.sv
`timescale 1ns/1ps
module pc_fetch_front_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] imem_addr;
  logic [15:0] imem_rdata;
  logic [15:0] ex_instr;
  logic [15:0] ex_pc;
  logic [1:0]  kind = 2'b00;
  logic        taken = 1'b0;
  logic [15:0] regt = 16'h0000;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [15:0] m_pc, m_ir, m_expc;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  function automatic logic [15:0] memf(input logic [15:0] a);
    logic [15:0] p;
    p = 16'(a * 16'h6B43);
    return p ^ {a[7:0], a[15:8]} ^ 16'h2C1D;
  endfunction

  assign imem_rdata = memf(imem_addr);

  pc_fetch_front u_pc_fetch_front (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .ex_instr(ex_instr), .ex_pc(ex_pc), .ex_redir_kind(kind),
    .ex_br_taken(taken), .ex_reg_target(regt)
  );

  task automatic compare(input string tag);
    checks++;
    if (imem_addr !== m_pc || ex_instr !== m_ir || ex_pc !== m_expc) begin
      failures++;
      $display("FAIL %s addr=%h/%h instr=%h/%h pc=%h/%h", tag,
               imem_addr, m_pc, ex_instr, m_ir, ex_pc, m_expc);
    end
  endtask

  // Drive one cycle of execute resolution, advance the model, compare after the edge.
  task automatic step(input logic [1:0] k, input logic t, input logic [15:0] rt, input string tag);
    logic        redir;
    logic [15:0] tgt, sext;
    kind = k; taken = t; regt = rt;
    sext  = {{8{m_ir[7]}}, m_ir[7:0]};
    redir = 1'b0;
    tgt   = 16'(m_pc + 16'd1);
    case (k)
      2'b01: if (t) begin redir = 1'b1; tgt = 16'(m_expc + 16'd1 + sext); end
      2'b10: begin redir = 1'b1; tgt = {m_expc[15:12], m_ir[11:0]}; end
      2'b11: begin redir = 1'b1; tgt = rt; end
      default: ;
    endcase
    @(posedge clk);
    m_ir   = redir ? 16'h0000 : memf(m_pc);
    m_expc = m_pc;
    m_pc   = tgt;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_pc = 16'h0; m_ir = 16'h0; m_expc = 16'h0;
    repeat (3) @(negedge clk);
    compare("R1 reset state");
    rst = 1'b0;
    step(2'b00, 1'b0, 16'h0, "R2 startup nop then word 0");
    step(2'b00, 1'b0, 16'h0, "R2 R4 first fetched word");
    step(2'b00, 1'b0, 16'h0, "R3 sequential");
    step(2'b01, 1'b0, 16'h0, "R6 not-taken branch");
    step(2'b00, 1'b1, 16'h0, "R10 taken flag ignored with kind none");
    step(2'b10, 1'b1, 16'h0, "R7 absolute jump");
    step(2'b00, 1'b0, 16'h0, "R9 squashed slot");
    step(2'b00, 1'b0, 16'h0, "R4 capture after jump");
    step(2'b01, 1'b1, 16'h0, "R5 taken branch");
    step(2'b11, 1'b0, 16'hFFFD, "R8 register jump");
    step(2'b00, 1'b0, 16'h0, "R3 near top");
    step(2'b00, 1'b0, 16'h0, "R3 near top");
    step(2'b00, 1'b0, 16'h0, "R3 R11 wrap");
    step(2'b01, 1'b1, 16'h0, "R5 R11 branch at wrap");
    step(2'b11, 1'b1, 16'hB7F0, "R8 R10 jump to page B");
    step(2'b00, 1'b0, 16'h0, "R4 page B fetch");
    step(2'b10, 1'b0, 16'h0, "R7 page kept from held PC");
    step(2'b11, 1'b0, 16'h1234, "R9 back-to-back redirect");
    step(2'b00, 1'b0, 16'h0, "R9 after back-to-back");
    rst = 1'b1;
    @(negedge clk);
    m_pc = 16'h0; m_ir = 16'h0; m_expc = 16'h0;
    compare("R1 reset mid-run");
    rst = 1'b0;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[1:0] & {lfsr[5], 1'b1}, lfsr[7], {lfsr[3:0], lfsr[15:4]}, "R9 R5 random mix");
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule